// File: doc/BRIEF.md
# GPIO Port Input Debounce Filter

This block sits between the pads of one eight-pin GPIO port and the logic that reads them or raises interrupts on them. Each raw pin is first brought into the clock domain through a short synchronizer. When filtering is active for a pin, a new level is passed on only after it has stayed unchanged for a programmed number of millisecond ticks. When filtering is not active for a pin, the synchronized level goes straight through with one register of delay.

All pins of the port share one 8-bit time value, counted in ticks of an external one-millisecond strobe. The top value is 255 ms. Each pin has its own filter enable bit. Software can write all eight bits at once through a direct address. It can also change any subset of them, without a read-modify-write, through a masked alias address. A time value of zero disables filtering on every pin, whatever the enable bits hold.

Top module: `gpio_dbnc_port`

## Requirements
- R1: While `rst_ni` is low, `pin_o` is 0, the time value is 0 and all enable bits are 0, whatever `pin_i` holds.
- R2: For a pin whose enable bit is 0, a level change on `pin_i` shows on `pin_o` at the third rising clock edge after it is applied: two synchronizer stages, then the output register.
- R3: When the time value is 0, every pin behaves as in R2, even with its enable bit set.
- R4: A write to address 0 loads `reg_wdata_i[7:0]` into the time value. A read of address 0 returns the time value in bits [7:0], with zeros above.
- R5: A write to address 1 loads all eight enable bits from `reg_wdata_i[7:0]`. A read of address 1 returns them in bits [7:0], with zeros above.
- R6: A write to address 2 changes only the enable bits of pins n whose select bit `reg_wdata_i[8+n]` is 1, setting each to `reg_wdata_i[n]`. All other enable bits keep their value. A read of address 2 returns the enable bits in [7:0], with zeros above. A read of address 3 returns 0.
- R7: For a pin with filtering active and time value N, once the synchronized level differs from `pin_o` and has held for one clock, `pin_o` takes it at the clock edge that samples the N-th tick. It does not change earlier.
- R8: Any change of the synchronized level of a filtered pin restarts its count. A pulse that returns to the output level before N ticks leaves `pin_o` unchanged, and a later change again needs N full ticks.
- R9: The output of a pin with filtering active changes only at a clock edge where `tick_i` is high. Without ticks it holds indefinitely.
- R10: Pins are filtered independently: a filtered pin waits for its ticks while an unfiltered pin in the same port passes straight through.
- R11: If the time value is lowered below the ticks already counted for a pending change, that change is applied at the next tick.
- R12: Clearing a pin's enable while a change is pending makes `pin_o` follow the synchronized level at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | Raw pad levels, asynchronous |
| tick_i | input | 1 | One-clock strobe, once per millisecond |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 time value, 1 enables, 2 masked enables |
| reg_wdata_i | input | 16 | Write data; [15:8] are the select bits for address 2 |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i`, combinational |
| pin_o | output | 8 | Filtered pin levels |

## Verification
A register write takes effect at the edge that samples the strobe, and read data is combinational, so the bench reads one cycle after a write. An unfiltered pin is due three edges after `pin_i` changes. The bench checks the old level after two edges and the new level after the third. A filtered change becomes eligible for counting from the fourth edge, so the bench waits three cycles after changing the pin before it pulses any tick. It checks `pin_o` on the falling edge after tick N-1 (old level) and after tick N (new level). The enable-clear case expects the new level one edge after the write edge.

// File: rtl/gpio_dbnc_pkg.sv
package gpio_dbnc_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_LIMIT  = 2'd0,
    ADDR_EN     = 2'd1,
    ADDR_EN_MSK = 2'd2,
    ADDR_NONE   = 2'd3
  } dbnc_addr_e;
endpackage

// File: rtl/gpio_dbnc_sync.sv
module gpio_dbnc_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= '0;
        else         stg_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q <= '0;
        else         stg_q <= {stg_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_dbnc_regs.sv
module gpio_dbnc_regs
  import gpio_dbnc_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned DATA_W   = 2 * NUM_PINS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [NUM_PINS-1:0] en_o,
  output logic [CNT_W-1:0]    limit_o
);
  logic [NUM_PINS-1:0] en_q, en_d;
  logic [CNT_W-1:0]    limit_q, limit_d;
  logic [NUM_PINS-1:0] sel_bits, val_bits;
  dbnc_addr_e          addr;

  assign addr     = dbnc_addr_e'(addr_i);
  assign sel_bits = wdata_i[2*NUM_PINS-1:NUM_PINS];
  assign val_bits = wdata_i[NUM_PINS-1:0];

  always_comb begin
    en_d    = en_q;
    limit_d = limit_q;
    if (we_i) begin
      unique case (addr)
        ADDR_LIMIT:  limit_d = wdata_i[CNT_W-1:0];
        ADDR_EN:     en_d    = val_bits;
        ADDR_EN_MSK: en_d    = (en_q & ~sel_bits) | (val_bits & sel_bits);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      limit_q <= '0;
    end else begin
      en_q    <= en_d;
      limit_q <= limit_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr)
      ADDR_LIMIT:           rdata_o[CNT_W-1:0]    = limit_q;
      ADDR_EN, ADDR_EN_MSK: rdata_o[NUM_PINS-1:0] = en_q;
      default: ;
    endcase
  end

  assign en_o    = en_q;
  assign limit_o = limit_q;
endmodule

// File: rtl/gpio_dbnc_pin_filter.sv
module gpio_dbnc_pin_filter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic             tick_i,
  input  logic             active_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             filt_o
);
  logic             prev_q, filt_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;
  logic             moved, settled, expire;

  assign last_cnt = limit_i - CNT_W'(1);
  assign moved    = sync_i != prev_q;
  assign settled  = sync_i == filt_q;
  // a lowered limit must not strand a count already past it
  assign expire   = cnt_q >= last_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= sync_i;
      if (!active_i) begin
        filt_q <= sync_i;
        cnt_q  <= '0;
      end else if (moved || settled) begin
        cnt_q  <= '0;
      end else if (tick_i) begin
        if (expire) begin
          filt_q <= sync_i;
          cnt_q  <= '0;
        end else begin
          cnt_q  <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign filt_o = filt_q;
endmodule

// File: rtl/gpio_dbnc_port.sv
module gpio_dbnc_port
  import gpio_dbnc_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned DATA_W     = 2 * NUM_PINS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                tick_i,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic [NUM_PINS-1:0] pin_o
);
  logic [NUM_PINS-1:0] sync_q;
  logic [NUM_PINS-1:0] en_q;
  logic [CNT_W-1:0]    limit_q;
  logic                limit_nz;

  gpio_dbnc_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (sync_q)
  );

  gpio_dbnc_regs #(
    .NUM_PINS (NUM_PINS),
    .CNT_W    (CNT_W),
    .DATA_W   (DATA_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .en_o    (en_q),
    .limit_o (limit_q)
  );

  assign limit_nz = |limit_q;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_dbnc_pin_filter #(
      .CNT_W (CNT_W)
    ) u_filt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sync_i   (sync_q[p]),
      .tick_i   (tick_i),
      .active_i (en_q[p] & limit_nz),
      .limit_i  (limit_q),
      .filt_o   (pin_o[p])
    );
  end
endmodule

// File: rtl/gpio_dbnc_port_chk.sv
module gpio_dbnc_port_chk
  import gpio_dbnc_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned DATA_W   = 2 * NUM_PINS
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                tick_i,
  input logic [NUM_PINS-1:0] pin_o,
  input logic [NUM_PINS-1:0] sync_i,
  input logic [NUM_PINS-1:0] en_i,
  input logic [CNT_W-1:0]    limit_i,
  input logic                we_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [DATA_W-1:0]   wdata_i
);
  logic [NUM_PINS-1:0] bypass, active, sel, val;

  assign bypass = ~en_i | {NUM_PINS{limit_i == '0}};
  assign active = ~bypass;
  assign sel    = wdata_i[2*NUM_PINS-1:NUM_PINS];
  assign val    = wdata_i[NUM_PINS-1:0];

  AST_BYPASS_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_o ^ $past(sync_i)) & $past(bypass)) == '0); // R2

  AST_ACTIVE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick_i) |-> ((pin_o ^ $past(pin_o)) & $past(active)) == '0); // R9

  AST_CHANGE_TO_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_o ^ $past(pin_o)) & (pin_o ^ $past(sync_i))) == '0); // R7

  AST_MSK_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_EN_MSK) |=> ((en_i ^ $past(en_i)) & ~$past(sel)) == '0); // R6

  AST_MSK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_EN_MSK) |=> (en_i & $past(sel)) == ($past(val) & $past(sel))); // R6

  AST_LIMIT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_LIMIT) |=> limit_i == $past(wdata_i[CNT_W-1:0])); // R4

  AST_EN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_EN) |=> en_i == $past(val)); // R5
endmodule

bind gpio_dbnc_port gpio_dbnc_port_chk #(
  .NUM_PINS (NUM_PINS),
  .CNT_W    (CNT_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .pin_o   (pin_o),
  .sync_i  (sync_q),
  .en_i    (en_q),
  .limit_i (limit_q),
  .we_i    (reg_we_i),
  .addr_i  (reg_addr_i),
  .wdata_i (reg_wdata_i)
);

// File: tb/tb_gpio_dbnc_port.sv
module tb_gpio_dbnc_port;
  localparam int NP = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out;
  logic          we = 1'b0;
  logic [1:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  int            n_chk = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  gpio_dbnc_port dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pin_i       (pin_in),
    .tick_i      (tick),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .pin_o       (pin_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic set_pins(input logic [NP-1:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  task automatic prep(input logic [7:0] lim, input logic [7:0] en);
    wr(2'd1, 16'h0000);
    set_pins(8'h00);
    cycles(4);
    wr(2'd0, {8'h00, lim});
    wr(2'd1, {8'h00, en});
  endtask

  task automatic t_reset;
    logic [DW-1:0] d;
    pin_in = 8'hA5;
    cycles(4);
    chk("R1 pin_o in reset", pin_out, 8'h00);
    rd(2'd0, d); chk("R1 time value in reset", d, 16'h0000);
    rd(2'd1, d); chk("R1 enables in reset", d, 16'h0000);
    rst_n = 1'b1;
    cycles(3);
    chk("R2 follow after reset", pin_out, 8'hA5);
  endtask

  task automatic t_bypass;
    set_pins(8'h3C);
    cycles(2);
    chk("R2 two edges old", pin_out, 8'hA5);
    cycles(1);
    chk("R2 third edge new", pin_out, 8'h3C);
  endtask

  task automatic t_regs;
    logic [DW-1:0] d;
    wr(2'd0, 16'h00FF); rd(2'd0, d); chk("R4 time 255", d, 16'h00FF);
    wr(2'd0, 16'hAB12); rd(2'd0, d); chk("R4 upper ignored", d, 16'h0012);
    wr(2'd1, 16'h00F0); rd(2'd1, d); chk("R5 direct enables", d, 16'h00F0);
    wr(2'd2, 16'h0C04); rd(2'd2, d); chk("R6 masked set", d, 16'h00F4);
    rd(2'd1, d); chk("R6 alias matches", d, 16'h00F4);
    wr(2'd2, 16'h8000); rd(2'd2, d); chk("R6 masked clear", d, 16'h0074);
    wr(2'd2, 16'h00FF); rd(2'd2, d); chk("R6 no select no change", d, 16'h0074);
    rd(2'd3, d); chk("R6 addr 3 reads 0", d, 16'h0000);
  endtask

  task automatic t_zero_limit;
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h00FF);
    set_pins(8'h00);
    cycles(2);
    chk("R3 zero time two edges", pin_out, 8'h3C);
    cycles(1);
    chk("R3 zero time passes", pin_out, 8'h00);
  endtask

  task automatic t_debounce;
    prep(8'd4, 8'h01);
    set_pins(8'h01);
    cycles(3);
    cycles(20);
    chk("R9 holds without ticks", pin_out, 8'h00);
    ticks(3);
    chk("R7 rise before N", pin_out, 8'h00);
    ticks(1);
    chk("R7 rise at N", pin_out, 8'h01);
    set_pins(8'h00);
    cycles(3);
    ticks(3);
    chk("R7 fall before N", pin_out, 8'h01);
    ticks(1);
    chk("R7 fall at N", pin_out, 8'h00);
  endtask

  task automatic t_glitch;
    prep(8'd3, 8'h01);
    set_pins(8'h01);
    cycles(3);
    ticks(2);
    chk("R8 short pulse pending", pin_out, 8'h00);
    set_pins(8'h00);
    cycles(3);
    ticks(3);
    chk("R8 short pulse dropped", pin_out, 8'h00);
    set_pins(8'h01);
    cycles(3);
    ticks(2);
    chk("R8 count restarted", pin_out, 8'h00);
    ticks(1);
    chk("R8 full count passes", pin_out, 8'h01);
  endtask

  task automatic t_indep;
    prep(8'd2, 8'h01);
    set_pins(8'h03);
    cycles(3);
    chk("R10 unfiltered pin passes", pin_out, 8'h02);
    ticks(2);
    chk("R10 filtered pin after ticks", pin_out, 8'h03);
  endtask

  task automatic t_shrink;
    prep(8'd10, 8'h01);
    set_pins(8'h01);
    cycles(3);
    ticks(5);
    chk("R11 pending at 5 of 10", pin_out, 8'h00);
    wr(2'd0, 16'h0003);
    chk("R11 no change on write", pin_out, 8'h00);
    ticks(1);
    chk("R11 next tick applies", pin_out, 8'h01);
  endtask

  task automatic t_disable;
    prep(8'd5, 8'h01);
    set_pins(8'h01);
    cycles(3);
    ticks(2);
    chk("R12 pending", pin_out, 8'h00);
    wr(2'd1, 16'h0000);
    chk("R12 write edge holds", pin_out, 8'h00);
    cycles(1);
    chk("R12 follows after clear", pin_out, 8'h01);
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_regs();
    t_zero_limit();
    t_debounce();
    t_glitch();
    t_indep();
    t_shrink();
    t_disable();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule